// File: doc/BRIEF.md
# Page-Mode Asynchronous Memory Host Controller

This block sits on the host side of an asynchronous byte-wide memory and turns one-byte requests, presented with a valid/ready handshake, into chip-enable, write-enable, output-enable and address sequences. The memory is arranged in rows of eight bytes. The low three address bits select the column and the bits above them select the row. Read data comes back on a one-cycle response strobe. Requests complete in the order they are accepted.

When a row is open, chip enable stays low. A request to the same row is accepted straight away and served as a column-only page access. A request to a different row is held off until the open row has been low long enough for both the minimum active time and the minimum random cycle time. Chip enable is then raised, the precharge gap is waited out, the new address is set up, and the new row is opened. A burst inside one row is therefore a run of same-row requests. The ordering of the strobes and the host's data driver is fixed so that the two sides never drive the data bus at the same time.

Each timing is a parameter in nanoseconds. Together with the clock period, it is rounded up to whole clock cycles. Below, AS, CA, RC, PC, ACC, PAGE, WP, PWC and DS are the rounded counts for address setup, active time, random cycle, precharge, first access, page access, write pulse, write period and data setup.

Top module: `pgm_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, chip enable, write enable and output enable are high (inactive), the host data driver is off and no response is signalled.
- R2: Before each falling edge of chip enable, the address has been stable for at least AS cycles and chip enable has been high for at least PC cycles.
- R3: Each low period of chip enable lasts at least CA cycles. Consecutive falling edges of chip enable are at least RC cycles apart.
- R4: A read that opens a row returns the byte stored at its address. The byte is sampled no earlier than ACC cycles after chip enable falls.
- R5: While chip enable is low, the row bits of the address never change. A request whose row bits equal those of the open row is served without another falling edge of chip enable.
- R6: A page read returns the byte at its new column. The byte is sampled no earlier than PAGE cycles after the column bits change.
- R7: Write enable goes low only after the address has been stable for AS cycles, and the address does not change while it is low. It stays low at least WP cycles, or at least ACC cycles on the access that opens the row. Its falling edges are at least PWC cycles apart. The written byte is driven for at least DS cycles before write enable rises.
- R8: Output enable is low only while chip enable is low, never while write enable is low, and never while the host data driver is on.
- R9: A request to a row other than the open one is not accepted (ready low) while chip enable is low. It is accepted only after a close and precharge.
- R10: A read returns the last byte written to that address, including a write made in the same open row.
- R11: Exactly one response is produced per accepted read and none for writes, in request order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken this cycle when valid is also high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte address; low CW bits are the column |
| req_wdata | input | DW | Byte to write |
| rsp_valid | output | 1 | One-cycle pulse carrying read data |
| rsp_rdata | output | DW | Read data |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_addr | output | AW | Memory address |
| mem_dq_out | output | DW | Byte driven toward the memory |
| mem_dq_oe | output | 1 | Host driver enable for the data bus |
| mem_dq_in | input | DW | Byte read from the memory |

## Verification
The cases where two functions land on the same cycle are the hard ones. The first is a request for a new row that arrives while the open row is still inside its minimum active time: the row close and the cycle-time limit both apply at once. The second is a read that follows a write in the same page: the release of the host driver and the fall of output enable must be ordered within one access. The bench provokes both with back-to-back requests that hold valid continuously, alternating rows and mixing reads and writes inside one row. A behavioural memory model returns corrupted data whenever sampling comes too early. It also measures every strobe interval in cycles against the rounded limits.

// File: rtl/pgm_pkg.sv
package pgm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,   // row closed, precharge satisfied
    ST_SETUP,  // address driven, chip enable still high
    ST_ACC,    // first access of a newly opened row
    ST_OPEN,   // row open, waiting for work
    ST_PSET,   // column changed, waiting before the strobe
    ST_PAGE,   // column access inside the open row
    ST_WREC,   // write enable high again, write period recovery
    ST_PRE     // chip enable high, precharge gap
  } pgm_state_e;

  // Nanoseconds to whole clock cycles, rounded up, never below one.
  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned clk_ps);
    int unsigned c;
    c = (ns * 1000 + clk_ps - 1) / clk_ps;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Shortest chip-enable low time that satisfies both the active time
  // and the fall-to-fall cycle once precharge and setup are added.
  function automatic int unsigned low_floor(input int unsigned ca, input int unsigned rc,
                                            input int unsigned pc, input int unsigned as_c);
    return (rc > pc + as_c) ? umax(ca, rc - pc - as_c) : ca;
  endfunction

  // Write enable high time needed after a page pulse to meet the period.
  function automatic int unsigned rec_len(input int unsigned pwc, input int unsigned wpl);
    return (pwc > wpl) ? pwc - wpl : 1;
  endfunction

endpackage

// File: rtl/pgm_timer.sv
module pgm_timer #(
  parameter int unsigned TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] len,
  output logic          done
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (load)        cnt_q <= len - TW'(1);
    else if (cnt_q != '0) cnt_q <= cnt_q - TW'(1);
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/pgm_age.sv
module pgm_age #(
  parameter int unsigned TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          run,
  output logic [TW-1:0] age
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age <= '0;
    else if (start)          age <= TW'(1);
    else if (run && !(&age)) age <= age + TW'(1);
  end
endmodule

// File: rtl/pgm_rowcmp.sv
module pgm_rowcmp #(
  parameter int unsigned AW = 17,
  parameter int unsigned CW = 3
) (
  input  logic [AW-1:0] req_a,
  input  logic [AW-1:0] open_a,
  output logic          hit
);
  assign hit = (req_a[AW-1:CW] == open_a[AW-1:CW]);
endmodule

// File: rtl/pgm_ctrl.sv
module pgm_ctrl import pgm_pkg::*; #(
  parameter int unsigned AW        = 17,
  parameter int unsigned DW        = 8,
  parameter int unsigned CW        = 3,
  parameter int unsigned TW        = 16,
  parameter int unsigned CLK_PS    = 10000,
  parameter int unsigned T_AS_NS   = 5,
  parameter int unsigned T_CA_NS   = 60,
  parameter int unsigned T_RC_NS   = 350,
  parameter int unsigned T_PC_NS   = 290,
  parameter int unsigned T_ACC_NS  = 60,
  parameter int unsigned T_PAGE_NS = 25,
  parameter int unsigned T_WP_NS   = 15,
  parameter int unsigned T_PWC_NS  = 30,
  parameter int unsigned T_DS_NS   = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);
  // Cycle counts derived from the nanosecond parameters
  localparam int unsigned AS_C   = ns2cyc(T_AS_NS, CLK_PS);
  localparam int unsigned CA_C   = ns2cyc(T_CA_NS, CLK_PS);
  localparam int unsigned RC_C   = ns2cyc(T_RC_NS, CLK_PS);
  localparam int unsigned PC_C   = ns2cyc(T_PC_NS, CLK_PS);
  localparam int unsigned ACC_C  = ns2cyc(T_ACC_NS, CLK_PS);
  localparam int unsigned PAGE_C = ns2cyc(T_PAGE_NS, CLK_PS);
  localparam int unsigned WP_C   = ns2cyc(T_WP_NS, CLK_PS);
  localparam int unsigned PWC_C  = ns2cyc(T_PWC_NS, CLK_PS);
  localparam int unsigned DS_C   = ns2cyc(T_DS_NS, CLK_PS);
  localparam int unsigned LOW_C  = low_floor(CA_C, RC_C, PC_C, AS_C);
  localparam int unsigned WPL_C  = umax(WP_C, DS_C);
  localparam int unsigned FWL_C  = umax(ACC_C, WPL_C);
  localparam int unsigned WH_C   = rec_len(PWC_C, WPL_C);

  localparam logic [TW-1:0] AS_L   = TW'(AS_C);
  localparam logic [TW-1:0] PC_L   = TW'(PC_C);
  localparam logic [TW-1:0] ACC_L  = TW'(ACC_C);
  localparam logic [TW-1:0] PAGE_L = TW'(PAGE_C);
  localparam logic [TW-1:0] WPL_L  = TW'(WPL_C);
  localparam logic [TW-1:0] FWL_L  = TW'(FWL_C);
  localparam logic [TW-1:0] WH_L   = TW'(WH_C);
  localparam logic [TW-1:0] LOW_L  = TW'(LOW_C);

  pgm_state_e    state_q, state_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          wr_q;
  logic          rsp_valid_q;
  logic [DW-1:0] rsp_data_q;

  logic          tmr_load;
  logic [TW-1:0] tmr_len;
  logic          tmr_done;
  logic [TW-1:0] ce_age;

  // Named internal events, also watched by the checker
  logic row_hit, accept, in_access, acc_last, rd_capture, close_go, age_start;

  pgm_rowcmp #(.AW(AW), .CW(CW)) u_rowcmp (
    .req_a(req_addr), .open_a(addr_q), .hit(row_hit)
  );

  pgm_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .len(tmr_len), .done(tmr_done)
  );

  pgm_age #(.TW(TW)) u_age (
    .clk(clk), .rst_n(rst_n), .start(age_start), .run(!mem_ce_n), .age(ce_age)
  );

  assign in_access  = (state_q == ST_ACC) || (state_q == ST_PAGE);
  assign req_ready  = (state_q == ST_IDLE) || ((state_q == ST_OPEN) && row_hit);
  assign accept     = req_valid && req_ready;
  assign close_go   = (state_q == ST_OPEN) && req_valid && !row_hit && (ce_age >= LOW_L);
  assign acc_last   = in_access && tmr_done;
  assign rd_capture = acc_last && !wr_q;
  assign age_start  = (state_q == ST_SETUP) && tmr_done;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_len  = AS_L;
    case (state_q)
      ST_IDLE: if (accept) begin
        state_d = ST_SETUP; tmr_load = 1'b1; tmr_len = AS_L;
      end
      ST_SETUP: if (tmr_done) begin
        state_d = ST_ACC; tmr_load = 1'b1; tmr_len = wr_q ? FWL_L : ACC_L;
      end
      ST_ACC, ST_PAGE: if (tmr_done) begin
        if (wr_q) begin
          state_d = ST_WREC; tmr_load = 1'b1; tmr_len = WH_L;
        end else begin
          state_d = ST_OPEN;
        end
      end
      ST_OPEN: begin
        if (accept) begin
          state_d = ST_PSET; tmr_load = 1'b1; tmr_len = AS_L;
        end else if (close_go) begin
          state_d = ST_PRE; tmr_load = 1'b1; tmr_len = PC_L;
        end
      end
      ST_PSET: if (tmr_done) begin
        state_d = ST_PAGE; tmr_load = 1'b1; tmr_len = wr_q ? WPL_L : PAGE_L;
      end
      ST_WREC: if (tmr_done) state_d = ST_OPEN;
      ST_PRE:  if (tmr_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      addr_q      <= '0;
      wdata_q     <= '0;
      wr_q        <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= rd_capture;
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        wr_q    <= req_write;
      end
      if (rd_capture) rsp_data_q <= mem_dq_in;
    end
  end

  assign mem_ce_n   = (state_q == ST_IDLE) || (state_q == ST_SETUP) || (state_q == ST_PRE);
  assign mem_oe_n   = !(in_access && !wr_q);
  assign mem_we_n   = !(in_access && wr_q);
  assign mem_dq_oe  = wr_q && (in_access || (state_q == ST_PSET) || (state_q == ST_WREC));
  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign rsp_valid  = rsp_valid_q;
  assign rsp_rdata  = rsp_data_q;
endmodule

// File: rtl/pgm_ctrl_chk.sv
module pgm_ctrl_chk #(
  parameter int unsigned AW   = 17,
  parameter int unsigned CW   = 3,
  parameter int unsigned CA_C = 6,
  parameter int unsigned PC_C = 29
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          row_hit,
  input logic          rsp_valid,
  input logic          mem_ce_n,
  input logic          mem_we_n,
  input logic          mem_oe_n,
  input logic          mem_dq_oe,
  input logic [AW-1:0] mem_addr
);
  localparam logic [15:0] CA_L = 16'(CA_C);
  localparam logic [15:0] PC_L = 16'(PC_C);

  logic [15:0] lo_cnt, hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt <= '0;
      hi_cnt <= PC_L;
    end else if (mem_ce_n) begin
      lo_cnt <= '0;
      if (!(&hi_cnt)) hi_cnt <= hi_cnt + 16'd1;
    end else begin
      hi_cnt <= '0;
      if (!(&lo_cnt)) lo_cnt <= lo_cnt + 16'd1;
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) $rose(rst_n) |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe)); // R1
  AST_ADDR_HELD_AT_OPEN: assert property (@(posedge clk) disable iff (!rst_n) $fell(mem_ce_n) |-> $stable(mem_addr)); // R2
  AST_PRECHARGE_GAP: assert property (@(posedge clk) disable iff (!rst_n) $fell(mem_ce_n) |-> (hi_cnt >= PC_L)); // R2
  AST_ACTIVE_MIN: assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_ce_n) |-> (lo_cnt >= CA_L)); // R3
  AST_ROW_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) (!mem_ce_n && !$past(mem_ce_n)) |-> (mem_addr[AW-1:CW] == $past(mem_addr[AW-1:CW]))); // R5
  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n) !mem_oe_n |-> (!mem_dq_oe && mem_we_n && !mem_ce_n)); // R8
  AST_MISS_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && !row_hit && !mem_ce_n) |-> !req_ready); // R9
  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> $past(!mem_oe_n)); // R11
endmodule

bind pgm_ctrl pgm_ctrl_chk #(.AW(AW), .CW(CW), .CA_C(CA_C), .PC_C(PC_C)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .row_hit(row_hit), .rsp_valid(rsp_valid), .mem_ce_n(mem_ce_n),
  .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_oe(mem_dq_oe),
  .mem_addr(mem_addr)
);

// File: tb/test_pgm_ctrl.sv
`timescale 1ns/1ps
module test_pgm_ctrl;
  // Bench's own rounding of the timing limits for a 10 ns clock
  function automatic int cyc(input int ns);
    int c;
    c = ns / 10;
    if (ns % 10 != 0) c = c + 1;
    if (c < 1) c = 1;
    return c;
  endfunction
  localparam int AS_N = cyc(5), CA_N = cyc(60), RC_N = cyc(350), PC_N = cyc(290);
  localparam int ACC_N = cyc(60), PAGE_N = cyc(25), WP_N = cyc(15), PWC_N = cyc(30), DS_N = cyc(20);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, rsp_valid, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0] rsp_rdata, mem_dq_out;
  logic [7:0] mem_dq_in = '0;
  logic [16:0] mem_addr;

  always #5 clk = ~clk;

  pgm_ctrl i_pgm_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_ce_n(mem_ce_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int n_chk = 0, n_fail = 0, n_rd = 0, n_rsp = 0, ce_falls = 0, wd = 0;
  logic [7:0] mem_m [int];
  logic [7:0] ref_m [int];
  logic [7:0] exp_q [$];

  function automatic logic [7:0] mem_rd(input int a);
    return mem_m.exists(a) ? mem_m[a] : 8'h00;
  endfunction
  function automatic logic [7:0] ref_rd(input int a);
    return ref_m.exists(a) ? ref_m[a] : 8'h00;
  endfunction

  task automatic check(input bit ok, input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // Host side: present one request, hold it until taken
  task automatic issue(input bit wr, input logic [16:0] a, input logic [7:0] d);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
    if (wr) ref_m[int'(a)] = d;
    else begin
      exp_q.push_back(ref_rd(int'(a)));
      n_rd++;
    end
  endtask

  // Behavioural memory and strobe-interval reference, stepped every cycle
  logic p_ce = 1'b1, p_we = 1'b1, p_dqoe = 1'b0, we_first = 1'b0, addr_moved = 1'b0, first_fall = 1'b1;
  logic [16:0] p_addr = '0, wr_a = '0;
  logic [7:0] p_dq = '0, wr_d = '0;
  int hi_n = 1000, lo_n = 0, since_fall = 0, astab = 0, dstab = 0, we_lo = 0, we_since = 1000;
  int acc_cnt = 0, need = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      logic chg, ce_fell, we_fell;
      chg = (mem_addr != p_addr);
      astab = chg ? 1 : astab + 1;
      dstab = (mem_dq_oe && p_dqoe && mem_dq_out == p_dq) ? dstab + 1 : (mem_dq_oe ? 1 : 0);
      since_fall++;
      we_since++;
      ce_fell = p_ce && !mem_ce_n;
      we_fell = p_we && !mem_we_n;

      // R8: bus ownership and strobe exclusion
      check(!(mem_dq_oe && !mem_oe_n), "R8", "host driver on with OE low", mem_dq_oe, 0);
      check(!(!mem_oe_n && !mem_we_n), "R8", "OE and WE low together", mem_oe_n, 1);
      check(!(!mem_oe_n && mem_ce_n), "R8", "OE low without CE", mem_ce_n, 0);

      if (ce_fell) begin
        check(astab >= AS_N + 1, "R2", "address setup before CE fall", astab - 1, AS_N);
        check(hi_n >= PC_N, "R2", "precharge cycles", hi_n, PC_N);
        if (!first_fall) check(since_fall >= RC_N, "R3", "CE fall-to-fall cycles", since_fall, RC_N);
        first_fall = 1'b0;
        since_fall = 0;
        lo_n = 0;
        ce_falls++;
        acc_cnt = 0;
        need = ACC_N;
      end else if (!mem_ce_n && chg) begin
        check(mem_addr[16:3] == p_addr[16:3], "R5", "row bits changed under CE", int'(mem_addr[16:3]), int'(p_addr[16:3]));
        acc_cnt = 0;
        need = PAGE_N;
      end
      if (!p_ce && mem_ce_n) begin
        check(lo_n >= CA_N, "R3", "CE low cycles", lo_n, CA_N);
        hi_n = 0;
      end
      if (mem_ce_n) hi_n++; else lo_n++;
      acc_cnt++;

      if (we_fell) begin
        check(astab >= AS_N + 1, "R7", "address setup before WE fall", astab - 1, AS_N);
        if (!ce_fell) check(we_since >= PWC_N, "R7", "WE fall-to-fall cycles", we_since, PWC_N);
        we_first = ce_fell;
        we_since = 0;
        we_lo = 0;
        addr_moved = 1'b0;
      end
      if (!mem_we_n) begin
        we_lo++;
        if (chg && !we_fell) addr_moved = 1'b1;
        wr_a = mem_addr;
        wr_d = mem_dq_out;
      end
      if (!p_we && mem_we_n) begin
        check(we_lo >= (we_first ? ACC_N : WP_N), "R7", "WE low cycles", we_lo, we_first ? ACC_N : WP_N);
        check(dstab >= DS_N + 1, "R7", "data setup before WE rise", dstab - 1, DS_N);
        check(!addr_moved, "R7", "address moved while WE low", addr_moved, 0);
        mem_m[int'(wr_a)] = wr_d;
      end

      // R9: a different row is not taken while the row is open
      if (req_valid && !mem_ce_n && req_addr[16:3] != mem_addr[16:3])
        check(!req_ready, "R9", "ready for row miss while open", req_ready, 0);

      if (rsp_valid) begin
        n_rsp++;
        if (exp_q.size() == 0) check(1'b0, "R11", "response with no read pending", n_rsp, n_rd);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(rsp_rdata == e, "R4/R6/R10", "read data", rsp_rdata, e);
        end
      end

      // Memory data: corrupted until the access time has elapsed
      if (!mem_ce_n && !mem_oe_n && mem_we_n)
        mem_dq_in <= (acc_cnt >= need) ? mem_rd(int'(mem_addr)) : ~mem_rd(int'(mem_addr));
      else
        mem_dq_in <= 8'h00;

      p_ce = mem_ce_n; p_we = mem_we_n; p_addr = mem_addr; p_dq = mem_dq_out; p_dqoe = mem_dq_oe;
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", wd);
      finish_run();
    end
  end

  task automatic settle();
    repeat (60) @(posedge clk);
    #1;
  endtask

  initial begin
    int f0;
    logic [2:0] order [8];
    order = '{3'd5, 3'd2, 3'd7, 3'd0, 3'd3, 3'd6, 3'd1, 3'd4};
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs during reset
    check(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_valid, "R1", "idle outputs in reset",
          {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, rsp_valid}, 5'b11100);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    check(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_valid, "R1", "idle outputs after reset",
          {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, rsp_valid}, 5'b11100);
    @(posedge clk); #1;

    // R10/R5: write then read in one row, one row opening
    f0 = ce_falls;
    issue(1'b1, 17'h00010, 8'h3C);
    issue(1'b0, 17'h00010, 8'h00);
    settle();
    check(ce_falls - f0 == 1, "R5", "CE falls for same-row write+read", ce_falls - f0, 1);

    // R6/R5: page burst writes then scrambled page reads, one row opening
    f0 = ce_falls;
    for (int i = 0; i < 8; i++) issue(1'b1, {14'h2468, 3'(i)}, 8'h50 + 8'(i));
    for (int i = 0; i < 8; i++) issue(1'b0, {14'h2468, order[i]}, 8'h00);
    settle();
    check(ce_falls - f0 == 1, "R5", "CE falls for 16-access page burst", ce_falls - f0, 1);

    // R9/R4/R2: alternating rows and address extremes
    f0 = ce_falls;
    issue(1'b0, 17'h12345, 8'h00);
    issue(1'b0, 17'h00017, 8'h00);
    issue(1'b0, 17'h12341, 8'h00);
    issue(1'b1, 17'h1FFFF, 8'hA7);
    issue(1'b0, 17'h00000, 8'h00);
    issue(1'b0, 17'h1FFFF, 8'h00);
    settle();
    check(ce_falls - f0 == 5, "R9", "CE falls for alternating rows", ce_falls - f0, 5);

    // R10/R8: interleaved reads and writes inside one row
    f0 = ce_falls;
    issue(1'b1, 17'h0000A, 8'h11);
    issue(1'b0, 17'h0000A, 8'h00);
    issue(1'b1, 17'h0000A, 8'h22);
    issue(1'b1, 17'h0000B, 8'h33);
    issue(1'b0, 17'h0000A, 8'h00);
    issue(1'b0, 17'h0000B, 8'h00);
    settle();
    check(ce_falls - f0 == 1, "R5", "CE falls for mixed page traffic", ce_falls - f0, 1);

    // R11: one response per read, none left over
    check(n_rsp == n_rd, "R11", "responses versus reads", n_rsp, n_rd);
    check(exp_q.size() == 0, "R11", "reads left unanswered", exp_q.size(), 0);
    finish_run();
  end
endmodule